// File: doc/BRIEF.md
# Tag Memory with Built-in Equality Compare

This block is the tag half of a direct-mapped cache. It keeps one tag word per cache line, addressed by the line index, and can do four things. It can store a tag, return a stored tag, or compare a presented tag against the word at the index and raise a hit/miss flag. It can also wipe every stored tag to zero with a single clear command. The clear is used at power-up or system reset so that no stale tag can produce a false hit.

The control inputs are active low: select, write, output enable and clear. Clear wins over everything. After that come deselect, then write, then read, and compare comes last. The hit flag is low only for a failed compare and is high in every other mode. The flags of several instances can therefore be joined with a wired-AND to compare a wider tag, with each instance checking its own slice. All inputs are sampled on the rising clock edge. The data output, its enable and the hit flag are registered, so each result appears one cycle after its inputs.

Index width, tag width and the number of cycles writes stay locked after a clear are parameters. A further parameter chooses whether the data output is forced to zero or holds its last value while disabled.

Top module: `tag_store_cmp`

## Requirements
- R1: While clear (`clr_n_i`=0) is sampled, every stored word becomes zero whatever the other inputs are, a write presented at the same time is not stored, and in the next cycle `match_o`=1 and `tag_oe_o`=0.
- R2: When select is inactive (`cs_n_i`=1) and clear is inactive, nothing is stored. In the next cycle `match_o`=1, `tag_oe_o`=0 and `tag_o`=0 (default variant, `ZERO_OFF`=1).
- R3: A write (`cs_n_i`=0, `we_n_i`=0, clear inactive) stores `tag_i` at `idx_i` for either value of `oe_n_i`. In the next cycle `match_o`=1 and `tag_oe_o`=0.
- R4: A read (`cs_n_i`=0, `we_n_i`=1, `oe_n_i`=0) gives, in the next cycle, `tag_oe_o`=1, `match_o`=1 and `tag_o` equal to the word stored at `idx_i`.
- R5: A compare (`cs_n_i`=0, `we_n_i`=1, `oe_n_i`=1) gives, in the next cycle, `match_o`=1 if `tag_i` equals the word stored at `idx_i` and `match_o`=0 otherwise, with `tag_oe_o`=0. `match_o` is never 0 after any other mode.
- R6: Every output changes only on the clock edge that samples its inputs, exactly one cycle after the inputs are presented.
- R7: After `rst_n`, every word reads as zero, `match_o`=1 and `tag_oe_o`=0.
- R8: A write sampled within `CLR_RECOV` cycles after the last cycle in which clear was sampled is not stored. The first write after that window is stored.
- R9: A word that has not been written since the last clear or reset compares equal to a zero tag and unequal to any other tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| idx_i | input | IDX_W | Line index |
| tag_i | input | TAG_W | Tag to write or to compare |
| cs_n_i | input | 1 | Select, active low |
| we_n_i | input | 1 | Write enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| clr_n_i | input | 1 | Clear all words, active low |
| tag_o | output | TAG_W | Stored tag from a read |
| tag_oe_o | output | 1 | High when `tag_o` carries read data |
| match_o | output | 1 | Hit flag, low only on a failed compare |

## Verification
Every index is written with a distinct value, read back, and then compared against every possible tag value. This shows that the hit flag tracks equality alone and is not tied to the index or to a single value. Every select, write and output-enable combination is applied with and without clear, including a write with output enable active and a write while deselected. This separates mode priority from the data path. Writes are issued right after clear is released, inside the lock window and just past it, and unwritten words are compared with zero and with non-zero tags. These cases tell the clear-as-invalidate behaviour apart from real stored zeros.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   typedef enum logic [2:0] {
      TSC_CLEAR = 3'd0,
      TSC_IDLE  = 3'd1,
      TSC_WRITE = 3'd2,
      TSC_READ  = 3'd3,
      TSC_CMP   = 3'd4
   } tsc_mode_e;
endpackage

// File: rtl/tsc_mode_dec.sv
module tsc_mode_dec
   import tsc_pkg::*;
(
   input  logic      cs_n,
   input  logic      we_n,
   input  logic      oe_n,
   input  logic      clr_n,
   output tsc_mode_e mode
);
   // priority: clear, deselect, write, read, compare
   always_comb begin
      if (!clr_n)      mode = TSC_CLEAR;
      else if (cs_n)   mode = TSC_IDLE;
      else if (!we_n)  mode = TSC_WRITE;
      else if (!oe_n)  mode = TSC_READ;
      else             mode = TSC_CMP;
   end
endmodule

// File: rtl/tsc_recov.sv
module tsc_recov #(
   parameter int CLR_RECOV = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic wr_block
);
   generate
      if (CLR_RECOV == 0) begin : g_none
         assign wr_block = 1'b0;
      end else begin : g_cnt
         localparam int CW = $clog2(CLR_RECOV + 1);
         localparam logic [CW-1:0] LOAD = CW'(CLR_RECOV);
         logic [CW-1:0] cnt_q;
         always_ff @(posedge clk) begin
            if (!rst_n)              cnt_q <= '0;
            else if (clr)            cnt_q <= LOAD;
            else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
         end
         assign wr_block = (cnt_q != '0);
      end
   endgenerate
endmodule

// File: rtl/tsc_array.sv
module tsc_array #(
   parameter int IDX_W = 10,
   parameter int TAG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wipe,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] idx,
   input  logic [TAG_W-1:0] wdata,
   output logic [TAG_W-1:0] rdata
);
   localparam int DEPTH = 1 << IDX_W;

   logic [TAG_W-1:0] mem_q [DEPTH];
   logic [DEPTH-1:0] vld_q;

   always_ff @(posedge clk) begin
      if (wr_en && !wipe) mem_q[idx] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || wipe) vld_q <= '0;
      else if (wr_en)     vld_q[idx] <= 1'b1;
   end

   // an invalid word behaves as zero for both read and compare
   assign rdata = vld_q[idx] ? mem_q[idx] : '0;
endmodule

// File: rtl/tsc_outstage.sv
module tsc_outstage
   import tsc_pkg::*;
#(
   parameter int TAG_W    = 8,
   parameter bit ZERO_OFF = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  tsc_mode_e        mode,
   input  logic [TAG_W-1:0] stored,
   input  logic [TAG_W-1:0] probe,
   output logic [TAG_W-1:0] data_q,
   output logic             oe_q,
   output logic             match_q
);
   logic eq;
   assign eq = (stored == probe);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         oe_q    <= 1'b0;
         match_q <= 1'b1;
      end else begin
         oe_q    <= (mode == TSC_READ);
         match_q <= (mode == TSC_CMP) ? eq : 1'b1;
      end
   end

   generate
      if (ZERO_OFF) begin : g_zero
         always_ff @(posedge clk) begin
            if (!rst_n)                data_q <= '0;
            else if (mode == TSC_READ) data_q <= stored;
            else                       data_q <= '0;
         end
      end else begin : g_hold
         always_ff @(posedge clk) begin
            if (!rst_n)                data_q <= '0;
            else if (mode == TSC_READ) data_q <= stored;
         end
      end
   endgenerate
endmodule

// File: rtl/tag_store_cmp.sv
module tag_store_cmp
   import tsc_pkg::*;
#(
   parameter int IDX_W     = 10,
   parameter int TAG_W     = 8,
   parameter int CLR_RECOV = 2,
   parameter bit ZERO_OFF  = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] idx_i,
   input  logic [TAG_W-1:0] tag_i,
   input  logic             cs_n_i,
   input  logic             we_n_i,
   input  logic             oe_n_i,
   input  logic             clr_n_i,
   output logic [TAG_W-1:0] tag_o,
   output logic             tag_oe_o,
   output logic             match_o
);
   generate
      if (IDX_W < 1 || IDX_W > 12) begin : g_bad_idx
         $error("tag_store_cmp: IDX_W must be 1..12");
      end
      if (TAG_W < 1) begin : g_bad_tag
         $error("tag_store_cmp: TAG_W must be positive");
      end
      if (CLR_RECOV < 0 || CLR_RECOV > 255) begin : g_bad_rec
         $error("tag_store_cmp: CLR_RECOV must be 0..255");
      end
   endgenerate

   tsc_mode_e        mode;
   logic             wr_block;
   logic [TAG_W-1:0] stored;
   logic             wipe;
   logic             wr_en;

   tsc_mode_dec u_dec (
      .cs_n  (cs_n_i),
      .we_n  (we_n_i),
      .oe_n  (oe_n_i),
      .clr_n (clr_n_i),
      .mode  (mode)
   );

   assign wipe  = (mode == TSC_CLEAR);
   assign wr_en = (mode == TSC_WRITE) && !wr_block;

   tsc_recov #(.CLR_RECOV(CLR_RECOV)) u_rec (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (wipe),
      .wr_block (wr_block)
   );

   tsc_array #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_arr (
      .clk   (clk),
      .rst_n (rst_n),
      .wipe  (wipe),
      .wr_en (wr_en),
      .idx   (idx_i),
      .wdata (tag_i),
      .rdata (stored)
   );

   tsc_outstage #(.TAG_W(TAG_W), .ZERO_OFF(ZERO_OFF)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (mode),
      .stored  (stored),
      .probe   (tag_i),
      .data_q  (tag_o),
      .oe_q    (tag_oe_o),
      .match_q (match_o)
   );
endmodule

// File: rtl/tag_store_cmp_chk.sv
module tag_store_cmp_chk #(
   parameter int TAG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cs_n_i,
   input logic             we_n_i,
   input logic             oe_n_i,
   input logic             clr_n_i,
   input logic [TAG_W-1:0] tag_o,
   input logic             tag_oe_o,
   input logic             match_o
);
   AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n_i |=> (match_o && !tag_oe_o)); // R1
   AST_DESEL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && cs_n_i) |=> (match_o && !tag_oe_o)); // R2
   AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !cs_n_i && !we_n_i) |=> (match_o && !tag_oe_o)); // R3
   AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !cs_n_i && we_n_i && !oe_n_i) |=> (match_o && tag_oe_o)); // R4
   AST_CMP_NO_OE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_n_i && !cs_n_i && we_n_i && oe_n_i) |=> !tag_oe_o); // R5
   AST_MISS_ONLY_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      !match_o |-> $past(clr_n_i && !cs_n_i && we_n_i && oe_n_i)); // R5
   AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tag_oe_o) |-> $past(clr_n_i && !cs_n_i && we_n_i && !oe_n_i)); // R6
endmodule

bind tag_store_cmp tag_store_cmp_chk #(.TAG_W(TAG_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cs_n_i   (cs_n_i),
   .we_n_i   (we_n_i),
   .oe_n_i   (oe_n_i),
   .clr_n_i  (clr_n_i),
   .tag_o    (tag_o),
   .tag_oe_o (tag_oe_o),
   .match_o  (match_o)
);

// File: tb/tag_store_cmp_tb_top.sv
module tag_store_cmp_tb_top;
   localparam int IW    = 4;
   localparam int TW    = 4;
   localparam int REC   = 2;
   localparam int NW    = 1 << IW;
   localparam int NT    = 1 << TW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [IW-1:0] idx_i = '0;
   logic [TW-1:0] tag_i = '0;
   logic          cs_n_i = 1'b1;
   logic          we_n_i = 1'b1;
   logic          oe_n_i = 1'b1;
   logic          clr_n_i = 1'b1;
   logic [TW-1:0] tag_o;
   logic          tag_oe_o;
   logic          match_o;

   int n_chk  = 0;
   int n_fail = 0;
   logic [TW-1:0] ref_mem [NW];
   int rec = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   tag_store_cmp #(.IDX_W(IW), .TAG_W(TW), .CLR_RECOV(REC), .ZERO_OFF(1'b1)) dut_i (
      .clk(clk), .rst_n(rst_n), .idx_i(idx_i), .tag_i(tag_i),
      .cs_n_i(cs_n_i), .we_n_i(we_n_i), .oe_n_i(oe_n_i), .clr_n_i(clr_n_i),
      .tag_o(tag_o), .tag_oe_o(tag_oe_o), .match_o(match_o)
   );

   task automatic check(input string rq, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
      end
   endtask

   // one operation: drive at negedge, model, wait edge, check at next negedge
   task automatic op(input logic cs_n, input logic we_n, input logic oe_n, input logic clr_n,
                     input int idx, input int tag, input string rq);
      int em, eo, ed;
      cs_n_i = cs_n; we_n_i = we_n; oe_n_i = oe_n; clr_n_i = clr_n;
      idx_i = IW'(idx); tag_i = TW'(tag);
      em = 1; eo = 0; ed = 0;
      if (!clr_n) begin
         for (int k = 0; k < NW; k++) ref_mem[k] = '0;
         rec = REC;
      end else begin
         if (!cs_n) begin
            if (!we_n) begin
               if (rec == 0) ref_mem[idx] = TW'(tag);
            end else if (!oe_n) begin
               eo = 1; ed = int'(ref_mem[idx]);
            end else begin
               em = (int'(ref_mem[idx]) == tag) ? 1 : 0;
            end
         end
         if (rec > 0) rec--;
      end
      @(posedge clk);
      @(negedge clk);
      check(rq, "match", int'(match_o), em);
      check(rq, "oe",    int'(tag_oe_o), eo);
      check(rq, "data",  int'(tag_o), ed);
   endtask

   task automatic read_all(input string rq);
      for (int i = 0; i < NW; i++) op(1'b0, 1'b1, 1'b0, 1'b1, i, 0, rq);
   endtask

   initial begin
      for (int k = 0; k < NW; k++) ref_mem[k] = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R7: state right after reset, held with reset active
      check("R7", "match", int'(match_o), 1);
      check("R7", "oe", int'(tag_oe_o), 0);
      check("R7", "data", int'(tag_o), 0);
      rst_n = 1'b1;
      read_all("R7");
      // R9: unwritten words hit on zero, miss otherwise
      for (int i = 0; i < NW; i++) begin
         op(1'b0, 1'b1, 1'b1, 1'b1, i, 0, "R9");
         op(1'b0, 1'b1, 1'b1, 1'b1, i, (i % (NT - 1)) + 1, "R9");
      end
      // R3: write every word, alternating output enable
      for (int i = 0; i < NW; i++)
         op(1'b0, 1'b0, 1'(i % 2), 1'b1, i, (i * 5 + 3) % NT, "R3");
      // R4 / R6: read back
      read_all("R4_R6");
      // R5: full sweep of index x tag
      for (int i = 0; i < NW; i++)
         for (int t = 0; t < NT; t++)
            op(1'b0, 1'b1, 1'b1, 1'b1, i, t, "R5");
      // R2: deselected with every we/oe combination, then read back
      for (int c = 0; c < 4; c++) op(1'b1, 1'(c / 2), 1'(c % 2), 1'b1, c, 15 - c, "R2");
      read_all("R2");
      // R1: clear with a write presented, and clear while deselected
      op(1'b0, 1'b0, 1'b0, 1'b0, 1, 9, "R1");
      op(1'b1, 1'b1, 1'b1, 1'b0, 2, 9, "R1");
      // R8: writes inside and just past the lock window
      op(1'b0, 1'b0, 1'b1, 1'b1, 2, 7, "R8");
      op(1'b0, 1'b0, 1'b1, 1'b1, 4, 6, "R8");
      op(1'b0, 1'b0, 1'b1, 1'b1, 3, 5, "R8");
      read_all("R1_R8");
      op(1'b0, 1'b1, 1'b1, 1'b1, 2, 7, "R8");
      op(1'b0, 1'b1, 1'b1, 1'b1, 3, 5, "R8");
      // R9 after clear: stored zero vs invalid
      op(1'b0, 1'b0, 1'b1, 1'b1, 5, 0, "R9");
      op(1'b0, 1'b1, 1'b1, 1'b1, 5, 0, "R9");
      op(1'b0, 1'b1, 1'b1, 1'b1, 6, 0, "R9");
      op(1'b0, 1'b1, 1'b1, 1'b1, 6, 1, "R9");
      // R1: clear during compare request, all reads zero after
      op(1'b0, 1'b1, 1'b1, 1'b0, 3, 5, "R1");
      op(1'b1, 1'b1, 1'b1, 1'b1, 0, 0, "R2");
      op(1'b1, 1'b1, 1'b1, 1'b1, 0, 0, "R2");
      read_all("R1");
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5 * 100000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule